// File: doc/BRIEF.md
# Power State and Wake Controller for a Card Interface

This block decides the power state of a smart card interface subsystem. It runs on the internal oscillator, which never stops. Software places it in one of two reduced-power states. In deep power-down the card is switched off. In sleep the card keeps its supply but is idle. The block leaves either state and returns to full operation when any of the following happens: a bit of the watched 8-bit port toggles, the card is inserted or removed, or the host issues a wake command. On the way back it raises a one-cycle interrupt.

An emergency deactivation request from the supervisory sequencer is accepted in every state. It removes card power in the same cycle and forces deep power-down. It also leaves a sticky fault flag that software clears. The outputs gate the controller clock, card power and the step-up converter. While the block sleeps, the converter runs only when a refresh of the boosted supply is requested.

Top module: `lpw_wake_ctrl`

## Requirements
- R1: After reset the state code `pstate` is 0 (run), `ctl_clk_en` is 1, `card_pwr_en` is 1, `wake_irq` is 0 and `fault_flag` is 0. State codes: 0 run, 1 power-down, 2 sleep, 3 wake.
- R2: In run, a command with `cmd_op`=1 moves the block to power-down on the next clock. There `ctl_clk_en`, `card_pwr_en` and `boost_en` are all 0.
- R3: In run, a command with `cmd_op`=2 moves the block to sleep on the next clock. There `ctl_clk_en` is 0 and `card_pwr_en` is 1.
- R4: A reduced-power state is entered only through a command or an emergency. Entry commands (`cmd_op` 1 or 2) issued while already in a reduced-power state have no effect on `pstate`.
- R5: In either reduced-power state, a toggle of any single bit of `port_in` brings the block to the wake state within four clocks.
- R6: A rising or falling edge on `card_present` in a reduced-power state brings the block to the wake state within four clocks.
- R7: A command with `cmd_op`=3 in a reduced-power state moves the block to the wake state on the next clock.
- R8: The wake state lasts exactly one clock, with `wake_irq`=1 and `ctl_clk_en`=1. The block is then in run.
- R9: While `emerg_deact` is 1, `card_pwr_en` and `boost_en` are 0 in that same cycle. On the next clock the block is in power-down with `fault_flag` set. This holds in every state.
- R10: `fault_flag` stays set until a `fault_clr` pulse clears it. While it is set, `card_pwr_en` is 0 in all states.
- R11: In sleep, `boost_en` equals `boost_refresh`. In run it is 1 when there is no fault.
- R12: In run, toggles of `port_in` or `card_present` raise no `wake_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_int | input | 1 | Always-running internal oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 2 | Command: 0 none, 1 power-down, 2 sleep, 3 wake |
| port_in | input | 8 | Watched general-purpose port, asynchronous |
| card_present | input | 1 | Card presence, asynchronous |
| emerg_deact | input | 1 | Emergency deactivation from the sequencer |
| boost_refresh | input | 1 | Request to restore the boosted supply |
| fault_clr | input | 1 | Clears the sticky fault flag |
| pstate | output | 2 | Current state code |
| ctl_clk_en | output | 1 | Controller clock enable |
| card_pwr_en | output | 1 | Card supply enable |
| boost_en | output | 1 | Step-up converter enable |
| wake_irq | output | 1 | One-cycle wake interrupt |
| fault_flag | output | 1 | Sticky emergency fault |

## Verification
The assertions assume three things about the inputs. First, `emerg_deact`, `cmd_valid` and `fault_clr` arrive synchronous to `clk_int`. Second, port and presence edges are slow enough that a toggle lasts longer than the two synchronizer stages. Third, a wake may follow from an input change that happens in the very cycle of entry. The stimulus meets these assumptions. It changes the watched inputs only after the block has settled in a reduced-power state, and it holds each new level for several clocks. It also pulses the synchronous controls for exactly one clock, driven just after an edge.

// File: rtl/lpw_pkg.sv
package lpw_pkg;
  typedef enum logic [1:0] {
    PS_RUN   = 2'd0,
    PS_DOWN  = 2'd1,
    PS_SLEEP = 2'd2,
    PS_WAKE  = 2'd3
  } pstate_e;

  localparam logic [1:0] OP_NOP   = 2'd0;
  localparam logic [1:0] OP_DOWN  = 2'd1;
  localparam logic [1:0] OP_SLEEP = 2'd2;
  localparam logic [1:0] OP_WAKE  = 2'd3;
endpackage

// File: rtl/lpw_sync.sv
module lpw_sync #(
  parameter int WIDTH  = 9,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] pipe_q [STAGES];
  logic [WIDTH-1:0] pipe_d [STAGES];

  always_comb begin
    pipe_d[0] = async_in;
    for (int i = 1; i < STAGES; i++) pipe_d[i] = pipe_q[i-1];
  end

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q[g] <= '0;
        else        pipe_q[g] <= pipe_d[g];
      end
    end
  endgenerate

  assign sync_out = pipe_q[STAGES-1];
endmodule

// File: rtl/lpw_change_det.sv
module lpw_change_det #(
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             armed,
  input  logic [WIDTH-1:0] watch_in,
  output logic             changed
);
  logic [WIDTH-1:0] snap_q, snap_d;

  // Snapshot tracks the inputs until armed, then freezes.
  always_comb snap_d = armed ? snap_q : watch_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) snap_q <= '0;
    else        snap_q <= snap_d;
  end

  assign changed = armed && (watch_in != snap_q);

  // R5
  snap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> (snap_q == $past(snap_q)));
endmodule

// File: rtl/lpw_fsm.sv
module lpw_fsm
  import lpw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic       wake_evt,
  input  logic       emerg,
  input  logic       fault_clr,
  output pstate_e    state,
  output logic       fault_q
);
  pstate_e state_q, state_d;
  logic    fault_d;
  logic    reduced;

  assign reduced = (state_q == PS_DOWN) || (state_q == PS_SLEEP);

  always_comb begin
    state_d = state_q;
    if (emerg) begin
      state_d = PS_DOWN;
    end else begin
      unique case (state_q)
        PS_RUN: begin
          if (cmd_valid && cmd_op == OP_DOWN)       state_d = PS_DOWN;
          else if (cmd_valid && cmd_op == OP_SLEEP) state_d = PS_SLEEP;
        end
        PS_DOWN, PS_SLEEP: begin
          if (wake_evt || (cmd_valid && cmd_op == OP_WAKE)) state_d = PS_WAKE;
        end
        PS_WAKE: state_d = PS_RUN;
        default: state_d = PS_RUN;
      endcase
    end
  end

  always_comb begin
    fault_d = fault_q;
    if (emerg)          fault_d = 1'b1;
    else if (fault_clr) fault_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_RUN;
      fault_q <= 1'b0;
    end else begin
      state_q <= state_d;
      fault_q <= fault_d;
    end
  end

  assign state = state_q;

  // R9
  emerg_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    emerg |=> (state_q == PS_DOWN) && fault_q);
  // R8
  wake_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_WAKE && !emerg) |=> (state_q == PS_RUN));
  // R4
  run_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_RUN && !cmd_valid && !emerg) |=> (state_q == PS_RUN));
  // R4
  reduced_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reduced && !wake_evt && !emerg && !(cmd_valid && cmd_op == OP_WAKE))
      |=> $stable(state_q));
  // R10
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q && !fault_clr) |=> fault_q);
endmodule

// File: rtl/lpw_wake_ctrl.sv
module lpw_wake_ctrl
  import lpw_pkg::*;
#(
  parameter int PORT_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_int,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [PORT_W-1:0] port_in,
  input  logic              card_present,
  input  logic              emerg_deact,
  input  logic              boost_refresh,
  input  logic              fault_clr,
  output logic [1:0]        pstate,
  output logic              ctl_clk_en,
  output logic              card_pwr_en,
  output logic              boost_en,
  output logic              wake_irq,
  output logic              fault_flag
);
  localparam int WATCH_W = PORT_W + 1;

  logic               rst_meta_q, rst_sync_n;
  logic [WATCH_W-1:0] watch_sync;
  logic               armed, changed;
  pstate_e            st;
  logic               fault_q;

  // Reset: asserted asynchronously, released on the clock.
  always_ff @(posedge clk_int or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  lpw_sync #(.WIDTH(WATCH_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk_int),
    .rst_n    (rst_sync_n),
    .async_in ({card_present, port_in}),
    .sync_out (watch_sync)
  );

  assign armed = (st == PS_DOWN) || (st == PS_SLEEP);

  lpw_change_det #(.WIDTH(WATCH_W)) u_det (
    .clk      (clk_int),
    .rst_n    (rst_sync_n),
    .armed    (armed),
    .watch_in (watch_sync),
    .changed  (changed)
  );

  lpw_fsm u_fsm (
    .clk       (clk_int),
    .rst_n     (rst_sync_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .wake_evt  (changed),
    .emerg     (emerg_deact),
    .fault_clr (fault_clr),
    .state     (st),
    .fault_q   (fault_q)
  );

  logic supply_ok;
  assign supply_ok = !fault_q && !emerg_deact;

  always_comb begin
    ctl_clk_en  = (st == PS_RUN) || (st == PS_WAKE);
    card_pwr_en = (st != PS_DOWN) && supply_ok;
    unique case (st)
      PS_DOWN:  boost_en = 1'b0;
      PS_SLEEP: boost_en = boost_refresh && supply_ok;
      default:  boost_en = supply_ok;
    endcase
  end

  assign pstate     = st;
  assign wake_irq   = (st == PS_WAKE);
  assign fault_flag = fault_q;

  // R3
  sleep_card_chk: assert property (@(posedge clk_int) disable iff (!rst_sync_n)
    (pstate == 2'd2 && !fault_flag && !emerg_deact) |-> card_pwr_en);
  // R2
  down_quiet_chk: assert property (@(posedge clk_int) disable iff (!rst_sync_n)
    (pstate == 2'd1) |-> !(card_pwr_en || boost_en || ctl_clk_en));
endmodule

// File: tb/sim_lpw_wake_ctrl.sv
module sim_lpw_wake_ctrl;
  logic       clk_int = 1'b0;
  logic       rst_n;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [7:0] port_in = 8'h5A;
  logic       card_present = 1'b1;
  logic       emerg_deact = 1'b0;
  logic       boost_refresh = 1'b0;
  logic       fault_clr = 1'b0;
  logic [1:0] pstate;
  logic       ctl_clk_en, card_pwr_en, boost_en, wake_irq, fault_flag;

  int checks = 0;
  int errors = 0;
  logic [1:0] exp_q [$];
  logic [1:0] prev_st;
  logic       mon_on = 1'b0;
  bit         done = 1'b0;

  always #10 clk_int = ~clk_int;

  lpw_wake_ctrl u0 (
    .clk_int, .rst_n, .cmd_valid, .cmd_op, .port_in, .card_present,
    .emerg_deact, .boost_refresh, .fault_clr, .pstate, .ctl_clk_en,
    .card_pwr_en, .boost_en, .wake_irq, .fault_flag
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_int); #1;
  endtask

  task automatic send(input logic [1:0] op);
    cmd_valid = 1'b1; cmd_op = op;
    step();
    cmd_valid = 1'b0; cmd_op = 2'd0;
  endtask

  // Scoreboard driver side: expect one wake interrupt coming from state 'from'.
  task automatic expect_wake(input logic [1:0] from);
    exp_q.push_back(from);
  endtask

  task automatic wait_wake(input string req);
    bit seen = 1'b0;
    for (int i = 0; i < 4 && !seen; i++) begin
      step();
      if (pstate == 2'd3) seen = 1'b1;
    end
    check(seen, req, pstate, 3);
    if (seen) begin
      check(ctl_clk_en == 1'b1, "R8", ctl_clk_en, 1);
      step();
      check(pstate == 2'd0 && wake_irq == 1'b0, "R8", pstate, 0);
    end
  endtask

  // Scoreboard monitor: each wake interrupt pops one expectation.
  always @(negedge clk_int) begin
    if (mon_on) begin
      if (wake_irq) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R12: actual unexpected wake_irq expected none");
        end else begin
          logic [1:0] e;
          e = exp_q.pop_front();
          if (prev_st != e) begin
            errors++;
            $display("FAIL R8: actual prior state %0d expected %0d", prev_st, e);
          end
        end
      end
      prev_st = pstate;
    end
  end

  initial begin
    #150000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();
    mon_on = 1'b1;
    prev_st = pstate;

    // R1 reset state
    check(pstate == 2'd0, "R1", pstate, 0);
    check(ctl_clk_en && card_pwr_en && !wake_irq && !fault_flag, "R1",
          {ctl_clk_en, card_pwr_en, wake_irq, fault_flag}, 4'b1100);
    check(boost_en == 1'b1, "R11", boost_en, 1);

    // R12 toggles in run are ignored
    port_in = 8'hA5; card_present = 1'b0;
    repeat (6) step();
    check(pstate == 2'd0, "R12", pstate, 0);
    card_present = 1'b1;
    repeat (4) step();

    // R2 enter power-down
    send(2'd1);
    check(pstate == 2'd1, "R2", pstate, 1);
    check(!ctl_clk_en && !card_pwr_en && !boost_en, "R2",
          {ctl_clk_en, card_pwr_en, boost_en}, 0);
    // R4 entry command ignored in reduced state
    send(2'd2);
    check(pstate == 2'd1, "R4", pstate, 1);
    repeat (3) step();
    check(pstate == 2'd1, "R4", pstate, 1);
    // R5 single port bit toggle wakes from power-down
    expect_wake(2'd1);
    port_in[0] = ~port_in[0];
    wait_wake("R5");

    // R3 sleep entry, R11 boost follows refresh
    repeat (4) step();
    send(2'd2);
    check(pstate == 2'd2 && !ctl_clk_en && card_pwr_en, "R3", pstate, 2);
    check(boost_en == 1'b0, "R11", boost_en, 0);
    boost_refresh = 1'b1; #1;
    check(boost_en == 1'b1, "R11", boost_en, 1);
    boost_refresh = 1'b0; #1;
    check(boost_en == 1'b0, "R11", boost_en, 0);
    send(2'd1);
    check(pstate == 2'd2, "R4", pstate, 2);
    // R5 top port bit wakes from sleep
    expect_wake(2'd2);
    port_in[7] = ~port_in[7];
    wait_wake("R5");

    // R6 card removal wakes from sleep
    repeat (4) step();
    send(2'd2);
    expect_wake(2'd2);
    card_present = 1'b0;
    wait_wake("R6");
    // R6 card insertion wakes from power-down
    repeat (4) step();
    send(2'd1);
    repeat (2) step();
    expect_wake(2'd1);
    card_present = 1'b1;
    wait_wake("R6");

    // R7 wake command
    repeat (4) step();
    send(2'd1);
    expect_wake(2'd1);
    send(2'd3);
    check(pstate == 2'd3 && wake_irq, "R7", pstate, 3);
    step();
    check(pstate == 2'd0, "R8", pstate, 0);

    // R9 emergency from sleep
    repeat (2) step();
    send(2'd2);
    emerg_deact = 1'b1; #1;
    check(!card_pwr_en && !boost_en, "R9", {card_pwr_en, boost_en}, 0);
    step();
    emerg_deact = 1'b0;
    check(pstate == 2'd1 && fault_flag, "R9", pstate, 1);
    // R10 fault persists across wake, card stays off
    expect_wake(2'd1);
    send(2'd3);
    step();
    check(pstate == 2'd0 && fault_flag && !card_pwr_en, "R10",
          {fault_flag, card_pwr_en}, 2'b10);
    repeat (3) step();
    check(fault_flag == 1'b1, "R10", fault_flag, 1);
    fault_clr = 1'b1;
    step();
    fault_clr = 1'b0;
    check(!fault_flag && card_pwr_en, "R10", {fault_flag, card_pwr_en}, 2'b01);

    // R9 emergency in run
    emerg_deact = 1'b1;
    step();
    emerg_deact = 1'b0;
    check(pstate == 2'd1 && fault_flag && !card_pwr_en, "R9", pstate, 1);
    fault_clr = 1'b1;
    step();
    fault_clr = 1'b0;
    expect_wake(2'd1);
    send(2'd3);
    repeat (3) step();

    check(exp_q.size() == 0, "R8", exp_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule